// File: doc/BRIEF.md
# Periodic Serial Bit Inverter

This block sits in a serial data path that carries one bit per clock together with a valid flag. It flips selected bits in a fixed pattern that repeats every three accepted bits. A single input picks between two patterns. In one pattern, one bit in each group of three is flipped. In the other, two bits in each group are flipped and the remaining one passes through. The flip itself is an exclusive-OR of the data bit with a mask bit. The mask comes from a small three-state sequencer.

There are two builds of the sequencer, chosen by a parameter. One is a three-flop circulating one-hot token, where a single flop of the ring is the mask. The other is a two-flop shift register with exclusive-OR feedback, seeded with all ones, where one flop is the mask. Both builds give the same output stream. The sequencer only steps on bits that are marked valid, so idle cycles do not shift the pattern. A synchronous reset restarts the pattern at a known phase. Data and valid leave the block through registers, one clock after they enter.

Top module: `bitinv_top`

## Requirements
- R1: With `two_of_three` low, the third, sixth, ninth and later accepted bits after reset (accepted-bit index 2 mod 3, counting from 0) are inverted. All other accepted bits are passed unchanged.
- R2: With `two_of_three` high, accepted bits at index 0 and 1 mod 3 are inverted, and bits at index 2 mod 3 are passed unchanged.
- R3: A bit that is not selected for inversion appears on `out_bit` equal to `in_bit`. A selected bit appears equal to `in_bit` XOR 1.
- R4: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_bit` = 0, and the accepted-bit index restarts at 0.
- R5: A cycle with `in_valid` low does not advance the pattern. One clock later it produces `out_valid` = 0 and `out_bit` = 0.
- R6: `out_valid` and `out_bit` are registered. The result for a bit presented in one clock cycle appears after the following rising edge.
- R7: A change of `two_of_three` applies from the next accepted bit onward and does not reset the accepted-bit index.
- R8: The ring build (`SEQ_KIND` = SEQ_RING) and the shift-register build (`SEQ_KIND` = SEQ_LFSR) produce identical outputs for identical input streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the pattern phase |
| in_bit | input | 1 | Incoming serial data bit |
| in_valid | input | 1 | High when `in_bit` carries a bit to process |
| two_of_three | input | 1 | 0: flip one bit in three; 1: flip two bits in three |
| out_bit | output | 1 | Processed data bit, registered |
| out_valid | output | 1 | Registered copy of `in_valid` |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge. They also assume that `in_valid`, `in_bit` and `two_of_three` are stable at each rising edge. The checker keeps its own modulo-three count of accepted bits, and the pattern checks rely on that count being restarted only by `rst`. The stimulus drives every input on the falling edge and holds reset high for the first several edges. It mixes idle cycles, mode flips and mid-stream resets, so the phase count is exercised across stalls and restarts.

// File: rtl/bitinv_pkg.sv
package bitinv_pkg;
  localparam int unsigned PERIOD = 3;
  localparam int unsigned RING_W = PERIOD;
  localparam int unsigned SHREG_W = 2;

  typedef enum logic {SEQ_RING = 1'b0, SEQ_LFSR = 1'b1} seq_kind_e;

  // hit marks the last slot of each three-bit group
  function automatic logic pick_mask(logic hit, logic two_of_three);
    return two_of_three ? ~hit : hit;
  endfunction

  function automatic logic flip(logic b, logic m);
    return b ^ m;
  endfunction
endpackage

// File: rtl/bitinv_ring.sv
module bitinv_ring
  import bitinv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic hit
);
  logic [RING_W-1:0] tok;

  always_ff @(posedge clk) begin
    if (rst) tok <= {1'b1, {(RING_W-1){1'b0}}};
    else if (step) tok <= {tok[0], tok[RING_W-1:1]};
  end

  // token reaches the low flop on the third slot: a direct tap, no decode
  assign hit = tok[0];
endmodule

// File: rtl/bitinv_lfsr.sv
module bitinv_lfsr
  import bitinv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic hit
);
  logic [SHREG_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {SHREG_W{1'b1}};
    else if (step) sr <= {sr[1] ^ sr[0], sr[1]};
  end

  // sr[0] runs 1,1,0,...; its complement marks the third slot
  assign hit = ~sr[0];
endmodule

// File: rtl/bitinv_top.sv
module bitinv_top
  import bitinv_pkg::*;
#(
  parameter seq_kind_e SEQ_KIND = SEQ_RING
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  input  logic two_of_three,
  output logic out_bit,
  output logic out_valid
);
  logic accept;
  logic phase_hit;
  logic flip_mask;

  assign accept = in_valid;

  generate
    if (SEQ_KIND == SEQ_RING) begin : g_ring
      bitinv_ring u_seq (.clk(clk), .rst(rst), .step(accept), .hit(phase_hit));
    end else begin : g_lfsr
      bitinv_lfsr u_seq (.clk(clk), .rst(rst), .step(accept), .hit(phase_hit));
    end
  endgenerate

  assign flip_mask = pick_mask(phase_hit, two_of_three);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= accept;
      out_bit   <= accept ? flip(in_bit, flip_mask) : 1'b0;
    end
  end
endmodule

// File: rtl/bitinv_chk.sv
module bitinv_chk (
  input logic clk,
  input logic rst,
  input logic in_bit,
  input logic in_valid,
  input logic two_of_three,
  input logic out_bit,
  input logic out_valid,
  input logic phase_hit,
  input logic flip_mask
);
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= 2'd0;
    else if (in_valid) cnt <= (cnt == 2'd2) ? 2'd0 : cnt + 2'd1;
  end

  assert_phase_R1: assert property (@(posedge clk) disable iff (rst)
    phase_hit == (cnt == 2'd2));

  assert_flip_one_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !two_of_three && cnt == 2'd2) |=> (out_bit != $past(in_bit)));

  assert_flip_two_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && two_of_three && cnt != 2'd2) |=> (out_bit != $past(in_bit)));

  assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (two_of_three == (cnt == 2'd2))) |=> (out_bit == $past(in_bit)));

  assert_reset_R4: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_bit));

  assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(phase_hit) && !out_valid && !out_bit));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_mask_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $changed(two_of_three)) |-> (flip_mask == (two_of_three ^ (cnt == 2'd2))));
endmodule

bind bitinv_top bitinv_chk u_chk (
  .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
  .two_of_three(two_of_three), .out_bit(out_bit), .out_valid(out_valid),
  .phase_hit(phase_hit), .flip_mask(flip_mask)
);

// File: tb/bitinv_top_test.sv
module bitinv_top_test;
  import bitinv_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic two_of_three = 1'b0;
  logic out_bit, out_valid, out_bit_l, out_valid_l;

  int checks = 0;
  int fails = 0;
  int k = 0;
  logic exp_v = 1'b0;
  logic exp_d = 1'b0;
  logic last_mode = 1'b0;
  string tag = "R4";
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitinv_top #(.SEQ_KIND(SEQ_RING)) uut (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .two_of_three(two_of_three), .out_bit(out_bit), .out_valid(out_valid));

  bitinv_top #(.SEQ_KIND(SEQ_LFSR)) uut_lfsr (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .two_of_three(two_of_three), .out_bit(out_bit_l), .out_valid(out_valid_l));

  // slot 2 of each group is the "odd" slot; mode 1 flips the other two
  function automatic logic model_flip(int idx, logic mode);
    logic third;
    third = (idx % 3) == 2;
    return mode ? !third : third;
  endfunction

  task automatic check(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", t, what, act, exp);
    end
  endtask

  task automatic verify();
    check("R6", "out_valid", out_valid, exp_v);
    check(tag, "out_bit", out_bit, exp_d);
    check("R8", "lfsr out_valid", out_valid_l, out_valid);
    check("R8", "lfsr out_bit", out_bit_l, out_bit);
  endtask

  // one cycle: check last result, then drive new inputs
  task automatic step(logic r, logic v, logic d, logic m);
    @(negedge clk);
    verify();
    rst = r; in_valid = v; in_bit = d; two_of_three = m;
    if (r) begin
      exp_v = 1'b0; exp_d = 1'b0; k = 0; tag = "R4";
    end else if (!v) begin
      exp_v = 1'b0; exp_d = 1'b0; tag = "R5";
    end else begin
      exp_v = 1'b1;
      exp_d = d ^ model_flip(k, m);
      if (m != last_mode) tag = "R7";
      else if (m) tag = "R2";
      else if (model_flip(k, m)) tag = "R1";
      else tag = "R3";
      last_mode = m;
      k++;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    // R1 directed: zeros in, expect 0,0,1,0,0,1
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    // R5 stalls between accepted bits keep phase
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    // R2 directed: ones in, mode 1
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
    // R7 mode toggles mid-group
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    // R4 mid-stream reset then restart of phase
    step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic r, v, d, m;
      r = ($urandom % 200) == 0;
      v = ($urandom % 4) != 0;
      d = $urandom % 2;
      m = (($urandom % 16) == 0) ? !two_of_three : two_of_three;
      step(r, v, d, m);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule